// File: doc/BRIEF.md
# Reconfigurable PLA Address Sequencer

This block is a tiny programmable state machine. Its next-state logic is a two-level programmable logic array with four inputs, four product terms and four outputs. The four outputs are registered and driven out in both true and complement form, where they serve as read and write addresses for a small operand register file. Feeding the registered outputs back as the next-cycle inputs lets the array step through any cyclic address pattern that fits in four product terms. Coefficients and data can then be fetched in a fixed, repeating order without any software involvement.

Before use, the array is programmed through a column port. Each of eight write cycles delivers six bits: four product-term selection bits for one literal, and two output-enable bits. After the eighth write a done flag rises and the machine is allowed to run. On every cycle, a select input chooses the source of the array's inputs. The source is either the externally supplied dual-rail inputs, which load a start state through the array, or the fed-back registered state.

Top module: `pla_addr_seq`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `addr` is 0, `addr_n` is all ones and `cfg_done` is 0.
- R2: Each clock edge with `cfg_we` high stores one configuration column. `cfg_done` stays 0 after seven writes, becomes 1 right after the edge of the eighth write, and then stays 1 until reset.
- R3: Literal index 2i is input i in true form and literal 2i+1 is input i in complement form. AND bit t*8+l selects literal l into term t. OR bit o*4+t enables term t into output o. Write number k (0..7) carries column bits [3:0] = AND bits t*8+k for t=0..3, and column bits [5:4] = OR bits 2k and 2k+1.
- R4: A product term with no selected literals evaluates to 1. An output with no enabled terms evaluates to 0.
- R5: When `sel_ext` is 1, the array inputs are taken from `ext_in` (true literals) and `ext_in_n` (complement literals).
- R6: When `sel_ext` is 0, the array inputs are the registered state and its complement, so a programmed function repeats its cycle from edge to edge.
- R7: The state register takes the array output only on edges where both `run` and `cfg_done` are 1. On any other edge it holds.
- R8: Configuration writes after `cfg_done` is 1 are ignored and do not change the programmed function.
- R9: `addr_n` is always the bitwise complement of `addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration column write strobe |
| cfg_col | input | 6 | Configuration column data |
| cfg_done | output | 1 | All eight columns written |
| run | input | 1 | Allow the state register to advance |
| sel_ext | input | 1 | 1: array inputs from external rails, 0: from state |
| ext_in | input | 4 | External inputs, true rail |
| ext_in_n | input | 4 | External inputs, complement rail |
| addr | output | 4 | Registered state / address, true form |
| addr_n | output | 4 | Registered state / address, complement form |

## Verification
The hardest condition to reach is a run of the machine from a state that its own cycle never passes through. A one-hot rotation, for example, stays at zero forever once it is there. The stimulus reaches such states by pulsing `sel_ext` for a single cycle with chosen rails, which pushes a start value through the array. The feedback loop is then checked over several full periods of both a binary counter and a non-binary rotation. Late configuration writes and held `run` are placed between running stretches, so that any damage to the state or to the programmed function would show up in the sequence that follows.

// File: rtl/pla_addr_seq_pkg.sv
// Package: default sizes shared by the sequencer modules.
package pla_addr_seq_pkg;
    parameter int unsigned DEF_WIDTH = 4;  // inputs = outputs = state bits
    parameter int unsigned DEF_TERMS = 4;  // product terms
endpackage

// File: rtl/pla_cfg_store.sv
// Configuration store: collects LIT columns, one per write, into the AND and
// OR plane bit vectors. Assumes OR_BITS is a multiple of LIT. Column k fills
// AND bits t*LIT+k and OR bits k*OPC+s. Writes after completion are dropped.
module pla_cfg_store #(
    parameter int unsigned N_TERM  = 4,
    parameter int unsigned LIT     = 8,
    parameter int unsigned OR_BITS = 16,
    localparam int unsigned OPC    = OR_BITS / LIT,
    localparam int unsigned COL_W  = N_TERM + OPC,
    localparam int unsigned CNT_W  = $clog2(LIT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [COL_W-1:0]         col,
    output logic [N_TERM*LIT-1:0]    and_cfg,
    output logic [OR_BITS-1:0]       or_cfg,
    output logic                     done
);
    logic [CNT_W-1:0] cnt;

    assign done = (cnt == CNT_W'(LIT));

    // Count accepted column writes up to LIT.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (we && !done)  cnt <= cnt + 1'b1;
    end

    for (genvar k = 0; k < LIT; k++) begin : g_col
        for (genvar t = 0; t < N_TERM; t++) begin : g_and
            // Capture AND bit for term t, literal k.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    and_cfg[t*LIT+k] <= 1'b0;
                else if (we && !done && cnt == CNT_W'(k))
                    and_cfg[t*LIT+k] <= col[t];
            end
        end
        for (genvar s = 0; s < OPC; s++) begin : g_or
            // Capture OR bit k*OPC+s.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    or_cfg[k*OPC+s] <= 1'b0;
                else if (we && !done && cnt == CNT_W'(k))
                    or_cfg[k*OPC+s] <= col[N_TERM+s];
            end
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
// AND plane: each term is the AND of its selected literals; a term with no
// selected literal is 1. Purely combinational.
module pla_and_plane #(
    parameter int unsigned N_TERM = 4,
    parameter int unsigned LIT    = 8
) (
    input  logic [LIT-1:0]        lits,
    input  logic [N_TERM*LIT-1:0] sel,
    output logic [N_TERM-1:0]     terms
);
    for (genvar t = 0; t < N_TERM; t++) begin : g_term
        // Unselected literals are forced to 1 before the reduction.
        assign terms[t] = &(lits | ~sel[t*LIT +: LIT]);
    end
endmodule

// File: rtl/pla_or_plane.sv
// OR plane: each output is the OR of its enabled terms; no enabled term
// gives 0. Purely combinational.
module pla_or_plane #(
    parameter int unsigned N_TERM = 4,
    parameter int unsigned N_OUT  = 4
) (
    input  logic [N_TERM-1:0]       terms,
    input  logic [N_OUT*N_TERM-1:0] en,
    output logic [N_OUT-1:0]        outs
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Disabled terms are masked to 0 before the reduction.
        assign outs[o] = |(terms & en[o*N_TERM +: N_TERM]);
    end
endmodule

// File: rtl/pla_addr_seq.sv
// Top: PLA-based address sequencer. The registered array outputs are the
// state and drive the dual-rail address. Array inputs come either from the
// external rails or from the fed-back state. The state advances only when
// run is high and configuration is complete.
module pla_addr_seq
    import pla_addr_seq_pkg::*;
#(
    parameter int unsigned WIDTH  = DEF_WIDTH,
    parameter int unsigned N_TERM = DEF_TERMS,
    localparam int unsigned LIT     = 2 * WIDTH,
    localparam int unsigned OR_BITS = WIDTH * N_TERM,
    localparam int unsigned COL_W   = N_TERM + OR_BITS / LIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [COL_W-1:0] cfg_col,
    output logic             cfg_done,
    input  logic             run,
    input  logic             sel_ext,
    input  logic [WIDTH-1:0] ext_in,
    input  logic [WIDTH-1:0] ext_in_n,
    output logic [WIDTH-1:0] addr,
    output logic [WIDTH-1:0] addr_n
);
    logic [N_TERM*LIT-1:0] and_cfg;
    logic [OR_BITS-1:0]    or_cfg;
    logic [LIT-1:0]        lits;
    logic [N_TERM-1:0]     terms;
    logic [WIDTH-1:0]      next_st;
    logic [WIDTH-1:0]      st_q;
    logic [WIDTH-1:0]      st_n_q;

    pla_cfg_store #(.N_TERM(N_TERM), .LIT(LIT), .OR_BITS(OR_BITS)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .col(cfg_col),
        .and_cfg(and_cfg), .or_cfg(or_cfg), .done(cfg_done)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_lit
        // Input multiplexer: external rails or state in both polarities.
        assign lits[2*i]   = sel_ext ? ext_in[i]   : st_q[i];
        assign lits[2*i+1] = sel_ext ? ext_in_n[i] : st_n_q[i];
    end

    pla_and_plane #(.N_TERM(N_TERM), .LIT(LIT)) u_and (
        .lits(lits), .sel(and_cfg), .terms(terms)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(WIDTH)) u_or (
        .terms(terms), .en(or_cfg), .outs(next_st)
    );

    // State register, true rail.
    always_ff @(posedge clk) begin
        if (!rst_n)                st_q <= '0;
        else if (run && cfg_done)  st_q <= next_st;
    end

    // State register, complement rail.
    always_ff @(posedge clk) begin
        if (!rst_n)                st_n_q <= '1;
        else if (run && cfg_done)  st_n_q <= ~next_st;
    end

    assign addr   = st_q;
    assign addr_n = st_n_q;
endmodule

// File: rtl/pla_addr_seq_chk.sv
// Checker: temporal properties of the sequencer, bound to the top module.
module pla_addr_seq_chk #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned CFG_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_done,
    input logic             run,
    input logic [WIDTH-1:0] addr,
    input logic [WIDTH-1:0] addr_n,
    input logic [CFG_W-1:0] cfg_bits
);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && cfg_done) |=> (addr == $past(addr)));

    p_done_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);

    p_done_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_we));

    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> $stable(cfg_bits));

    p_rails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_n == ~addr);
endmodule

bind pla_addr_seq pla_addr_seq_chk #(.WIDTH(WIDTH), .CFG_W(N_TERM*LIT+OR_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_done(cfg_done),
    .run(run), .addr(addr), .addr_n(addr_n), .cfg_bits({and_cfg, or_cfg})
);

// File: tb/pla_addr_seq_tb.sv
module pla_addr_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_col = '0;
    logic       cfg_done;
    logic       run = 1'b0;
    logic       sel_ext = 1'b0;
    logic [3:0] ext_in = '0;
    logic [3:0] ext_in_n = '1;
    logic [3:0] addr;
    logic [3:0] addr_n;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    pla_addr_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_col(cfg_col),
        .cfg_done(cfg_done), .run(run), .sel_ext(sel_ext), .ext_in(ext_in),
        .ext_in_n(ext_in_n), .addr(addr), .addr_n(addr_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected state per cycle and compares both rails.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {4'h0, addr}, {4'h0, e});
                check("R9", {4'h0, addr_n}, {4'h0, ~e});
            end
        end
    end

    // Driver: one cycle of stimulus, then queue the expected state.
    task automatic step(input logic s_ext, input logic r, input logic [3:0] x,
                        input logic [3:0] e, input string tag);
        @(negedge clk);
        sel_ext = s_ext; run = r; ext_in = x; ext_in_n = ~x;
        @(posedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic write_col(input int k, input logic [31:0] av, input logic [15:0] ov);
        @(negedge clk);
        cfg_we = 1'b1;
        for (int t = 0; t < 4; t++) cfg_col[t] = av[t*8+k];
        cfg_col[4] = ov[2*k];
        cfg_col[5] = ov[2*k+1];
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; sel_ext = 1'b0; cfg_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] av;
        logic [15:0] ov;
        logic [3:0]  s;

        // Modulo-4 counter: T0=~s0, T1=s1&~s0, T2=~s1&s0; out0=T0, out1=T1|T2 (R3).
        av = '0; ov = '0;
        av[0*8+1] = 1'b1;
        av[1*8+2] = 1'b1; av[1*8+1] = 1'b1;
        av[2*8+3] = 1'b1; av[2*8+0] = 1'b1;
        ov[0*4+0] = 1'b1; ov[1*4+1] = 1'b1; ov[1*4+2] = 1'b1;

        repeat (2) @(negedge clk);
        check("R1 addr", {4'h0, addr}, 8'h00);
        check("R1 addr_n", {4'h0, addr_n}, 8'h0f);
        check("R1 done", {7'h0, cfg_done}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {3'h0, cfg_done, addr}, 8'h00);

        run = 1'b1; // R7: run without configuration must not advance
        for (int k = 0; k < 7; k++) write_col(k, av, ov);
        check("R2 done after 7", {7'h0, cfg_done}, 8'h00);
        check("R7 hold unconfigured", {4'h0, addr}, 8'h00);
        run = 1'b0;
        write_col(7, av, ov);
        check("R2 done after 8", {7'h0, cfg_done}, 8'h01);

        s = 4'h0;
        for (int i = 0; i < 10; i++) begin
            s = (s + 4'h1) & 4'h3;
            step(1'b0, 1'b1, 4'h0, s, "R6 counter");
        end
        step(1'b0, 1'b0, 4'h0, s, "R7 hold run low");
        step(1'b0, 1'b0, 4'h0, s, "R7 hold run low");
        drain();

        // R8: late writes of zeros must be ignored.
        for (int k = 0; k < 8; k++) write_col(k, 32'h0, 16'h0);
        check("R8 state after late writes", {4'h0, addr}, {4'h0, s});
        check("R2 done stays", {7'h0, cfg_done}, 8'h01);
        for (int i = 0; i < 5; i++) begin
            s = (s + 4'h1) & 4'h3;
            step(1'b0, 1'b1, 4'h0, s, "R8 counter after late writes");
        end
        step(1'b1, 1'b1, 4'h2, 4'h3, "R5 ext load 2 gives 3");
        step(1'b0, 1'b1, 4'h0, 4'h0, "R6 counter wrap");
        step(1'b0, 1'b1, 4'h0, 4'h1, "R6 counter");
        drain();

        // Non-binary rotation 1->2->4->8 (R3, R6).
        do_reset();
        av = '0; ov = '0;
        av[0*8+0] = 1'b1; av[1*8+2] = 1'b1; av[2*8+4] = 1'b1; av[3*8+6] = 1'b1;
        ov[1*4+0] = 1'b1; ov[2*4+1] = 1'b1; ov[3*4+2] = 1'b1; ov[0*4+3] = 1'b1;
        for (int k = 0; k < 8; k++) write_col(k, av, ov);
        step(1'b0, 1'b1, 4'h0, 4'h0, "R6 rotation stuck at zero");
        step(1'b1, 1'b1, 4'h1, 4'h2, "R5 ext load through array");
        s = 4'h2;
        for (int i = 0; i < 9; i++) begin
            s = {s[2:0], s[3]};
            step(1'b0, 1'b1, 4'h0, s, "R6 rotation");
        end
        step(1'b1, 1'b1, 4'h5, 4'ha, "R5 ext load 5");
        step(1'b0, 1'b1, 4'h0, 4'h5, "R6 rotation 5");
        step(1'b0, 1'b1, 4'h0, 4'ha, "R6 rotation a");
        drain();

        // Empty term is 1, empty output is 0 (R4).
        do_reset();
        av = '0; ov = '0;
        ov[0] = 1'b1;
        for (int k = 0; k < 8; k++) write_col(k, av, ov);
        step(1'b0, 1'b1, 4'h0, 4'h1, "R4 empty term");
        step(1'b0, 1'b1, 4'h0, 4'h1, "R4 empty term");
        step(1'b1, 1'b1, 4'hf, 4'h1, "R4 empty outputs");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule